// File: doc/BRIEF.md
# Emergency Output Disable Detector

This block watches a small set of active-low emergency inputs and, once a fault condition is accepted on any of them, pulls the output enables of a group of high-current pins low so that those pads float. Each input is either edge-sensitive (a single high-to-low transition) or level-sensitive. In level mode, a falling edge starts a filter, and the filter must then see the input low on sixteen sampling ticks in a row.

Sampling ticks come from a prescaler on the system clock. Software chooses the prescaler ratio and the mode of each input through a configuration register. Every input has its own sticky fault flag. While any flag is set, the protected pins are held off. The force-off applies only to pins whose function select says they are in general I/O or timer-output use. Software releases the pins by writing zeros to the flags.

Top module: `fault_hiz_guard`

## Requirements
- R1: After reset all fault flags read 0 and every `pin_oe_out` bit equals `pin_oe_req`.
- R2: In edge mode (`cfg_level_mode` bit = 0), when the synchronized input goes from a high to a low sample on consecutive sampling ticks, the input's flag is set one clock after the accepting tick.
- R3: In level mode (`cfg_level_mode` bit = 1), a falling edge on a tick starts the filter and counts as the first low sample. The flag is set one clock after the tick that takes the sixteenth consecutive low sample, and not before.
- R4: A single high sample inside the level window rejects it without setting the flag. The detector then waits for a new falling edge, which starts a fresh sixteen-sample count.
- R5: An input that is already low, with no new high-to-low transition, never sets a flag in either mode, including after software clears its flag.
- R6: `cfg_div_sel` picks the tick period: 2'b00 gives one tick every 8 clocks, 2'b01 every 16, and 2'b10 or 2'b11 every 128. Edge and level modes have the same latency from the deciding tick to the flag.
- R7: While any flag is set, every pin with `pin_func_sel` = 1 has `pin_oe_out` = 0.
- R8: A pin with `pin_func_sel` = 0 always has `pin_oe_out` equal to `pin_oe_req`.
- R9: A flag write with `flag_we` = 1 clears each flag whose `flag_wdata` bit is 0. Bits written as 1 leave their flags unchanged. Flags never clear in any other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in_n | input | N_IN | Raw active-low emergency inputs (asynchronous) |
| cfg_we | input | 1 | Loads the configuration register |
| cfg_level_mode | input | N_IN | Per-input mode: 1 = filtered level, 0 = falling edge |
| cfg_div_sel | input | 2 | Sampling tick divider select |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | N_IN | Flag write data; 0 clears, 1 keeps |
| pin_func_sel | input | N_PIN | 1 = pin in general I/O or timer function |
| pin_oe_req | input | N_PIN | Output enables requested by the pin owners |
| pin_oe_out | output | N_PIN | Output enables delivered to the pads |
| fault_flags | output | N_IN | Sticky per-input fault flags |

## Verification
The hardest case to reach is a level-mode rejection followed by a restart. The input must fall, stay low for fewer than sixteen ticks, rise for at least one tick, and then fall again. The only evidence at the ports is that the flag appears late, measured from the second edge. The stimulus times these phases in multiples of the tick period. It also clears a flag while its input is still held low, to show that a stale low level does not re-arm the detector. A behavioural model of the prescaler and the filters is compared against the flags and the enables on every clock.

// File: rtl/fhg_pkg.sv
package fhg_pkg;
  typedef enum logic [1:0] {
    DIV_SLOW8   = 2'b00,
    DIV_SLOW16  = 2'b01,
    DIV_SLOW128 = 2'b10,
    DIV_SLOW128B = 2'b11
  } div_sel_t;

  typedef enum logic {
    DET_IDLE  = 1'b0,
    DET_COUNT = 1'b1
  } det_state_t;
endpackage

// File: rtl/fhg_prescaler.sv
module fhg_prescaler
  import fhg_pkg::*;
#(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_t div_sel,
  output logic     tick
);
  localparam int CNT_W = $clog2(DIV_C);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (div_sel)
      DIV_SLOW8:  last = CNT_W'(DIV_A - 1);
      DIV_SLOW16: last = CNT_W'(DIV_B - 1);
      default:    last = CNT_W'(DIV_C - 1);
    endcase
  end

  assign tick = (cnt_q >= last);

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6
endmodule

// File: rtl/fhg_detector.sv
module fhg_detector
  import fhg_pkg::*;
#(
  parameter int FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level_mode,
  input  logic pin_raw_n,
  output logic hit
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic       sync1_q, sync2_q;
  logic       prev_q, prev_d;
  det_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic       hit_q, hit_d;
  logic       fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= pin_raw_n;
      sync2_q <= sync1_q;
    end
  end

  assign fall = prev_q & ~sync2_q;

  always_comb begin
    prev_d = prev_q;
    st_d   = st_q;
    cnt_d  = cnt_q;
    hit_d  = 1'b0;
    if (tick) begin
      prev_d = sync2_q;
      case (st_q)
        DET_IDLE: begin
          if (fall) begin
            if (!level_mode || FILT_LEN == 1) begin
              hit_d = 1'b1;
            end else begin
              st_d  = DET_COUNT;
              cnt_d = CW'(1);
            end
          end
        end
        default: begin
          if (!level_mode || sync2_q) begin
            st_d  = DET_IDLE;
            cnt_d = '0;
          end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            hit_d = 1'b1;
            st_d  = DET_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      st_q   <= DET_IDLE;
      cnt_q  <= '0;
      hit_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hit_q  <= hit_d;
    end
  end

  assign hit = hit_q;

  AST_HIT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(tick)); // R2
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R3
  AST_COUNT_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DET_COUNT) |-> level_mode || $past(level_mode) || $past(st_q == DET_IDLE)); // R4
endmodule

// File: rtl/fhg_pin_gate.sv
module fhg_pin_gate (
  input  logic hiz,
  input  logic func_sel,
  input  logic oe_req,
  output logic oe_drv
);
  always_comb begin
    if (hiz && func_sel) oe_drv = 1'b0;
    else                 oe_drv = oe_req;
  end
endmodule

// File: rtl/fault_hiz_guard.sv
module fault_hiz_guard
  import fhg_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int N_PIN    = 6,
  parameter int FILT_LEN = 16,
  parameter int DIV_A    = 8,
  parameter int DIV_B    = 16,
  parameter int DIV_C    = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  fault_in_n,
  input  logic             cfg_we,
  input  logic [N_IN-1:0]  cfg_level_mode,
  input  logic [1:0]       cfg_div_sel,
  input  logic             flag_we,
  input  logic [N_IN-1:0]  flag_wdata,
  input  logic [N_PIN-1:0] pin_func_sel,
  input  logic [N_PIN-1:0] pin_oe_req,
  output logic [N_PIN-1:0] pin_oe_out,
  output logic [N_IN-1:0]  fault_flags
);
  div_sel_t        div_q, div_d;
  logic [N_IN-1:0] mode_q, mode_d;
  logic [N_IN-1:0] flags_q, flags_d;
  logic [N_IN-1:0] hit_vec;
  logic [N_IN-1:0] clr_mask;
  logic            tick;
  logic            hiz;

  always_comb begin
    div_d  = div_q;
    mode_d = mode_q;
    if (cfg_we) begin
      div_d  = div_sel_t'(cfg_div_sel);
      mode_d = cfg_level_mode;
    end
  end

  assign clr_mask = flag_we ? ~flag_wdata : '0;

  always_comb begin
    flags_d = (flags_q & ~clr_mask) | hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_SLOW8;
      mode_q  <= '0;
      flags_q <= '0;
    end else begin
      div_q   <= div_d;
      mode_q  <= mode_d;
      flags_q <= flags_d;
    end
  end

  fhg_prescaler #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) i_presc (
    .clk(clk), .rst_n(rst_n), .div_sel(div_q), .tick(tick)
  );

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_det
    fhg_detector #(.FILT_LEN(FILT_LEN)) i_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .level_mode(mode_q[gi]),
      .pin_raw_n (fault_in_n[gi]),
      .hit       (hit_vec[gi])
    );
  end

  assign hiz = |flags_q;

  for (genvar gp = 0; gp < N_PIN; gp++) begin : g_pin
    fhg_pin_gate i_gate (
      .hiz     (hiz),
      .func_sel(pin_func_sel[gp]),
      .oe_req  (pin_oe_req[gp]),
      .oe_drv  (pin_oe_out[gp])
    );
  end

  assign fault_flags = flags_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags_q) & ~flags_q)) |-> $past(flag_we)); // R9
  AST_FLAG_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ~$past(flags_q))) |-> (|$past(hit_vec))); // R2
  AST_HIZ_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) |-> ((pin_oe_out & pin_func_sel) == '0)); // R7
  AST_OTHER_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe_out & ~pin_func_sel) == (pin_oe_req & ~pin_func_sel)); // R8
endmodule

// File: tb/test_fault_hiz_guard.sv
module test_fault_hiz_guard;
  localparam int N_IN = 4;
  localparam int N_PIN = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_IN-1:0]  fault_in_n = '1;
  logic             cfg_we = 1'b0;
  logic [N_IN-1:0]  cfg_level_mode = '0;
  logic [1:0]       cfg_div_sel = 2'b00;
  logic             flag_we = 1'b0;
  logic [N_IN-1:0]  flag_wdata = '1;
  logic [N_PIN-1:0] pin_func_sel = 6'b001111;
  logic [N_PIN-1:0] pin_oe_req = 6'b111111;
  logic [N_PIN-1:0] pin_oe_out;
  logic [N_IN-1:0]  fault_flags;

  int checks = 0;
  int fails = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  fault_hiz_guard i_fault_hiz_guard (
    .clk(clk), .rst_n(rst_n), .fault_in_n(fault_in_n),
    .cfg_we(cfg_we), .cfg_level_mode(cfg_level_mode), .cfg_div_sel(cfg_div_sel),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .pin_func_sel(pin_func_sel), .pin_oe_req(pin_oe_req),
    .pin_oe_out(pin_oe_out), .fault_flags(fault_flags)
  );

  // behavioural reference
  int m_s1[N_IN], m_s2[N_IN], m_prev[N_IN], m_cnt[N_IN], m_hit[N_IN];
  bit m_counting[N_IN];
  bit [N_IN-1:0] m_flags, m_mode;
  int m_pc, m_period;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++) begin
        m_s1[i] = 1; m_s2[i] = 1; m_prev[i] = 1; m_cnt[i] = 0;
        m_hit[i] = 0; m_counting[i] = 0;
      end
      m_flags = '0; m_mode = '0; m_pc = 0; m_period = 8;
    end else begin
      bit t;
      t = (m_pc >= m_period - 1);
      m_pc = t ? 0 : m_pc + 1;
      for (int i = 0; i < N_IN; i++) begin
        if (flag_we && !flag_wdata[i]) m_flags[i] = 1'b0;
        if (m_hit[i] != 0) m_flags[i] = 1'b1;
        m_hit[i] = 0;
        if (t) begin
          if (!m_counting[i]) begin
            if (m_prev[i] == 1 && m_s2[i] == 0) begin
              if (!m_mode[i]) m_hit[i] = 1;
              else begin m_counting[i] = 1; m_cnt[i] = 1; end
            end
          end else if (!m_mode[i] || m_s2[i] == 1) begin
            m_counting[i] = 0;
          end else if (m_cnt[i] == 15) begin
            m_hit[i] = 1; m_counting[i] = 0;
          end else begin
            m_cnt[i]++;
          end
          m_prev[i] = m_s2[i];
        end
        m_s2[i] = m_s1[i];
        m_s1[i] = fault_in_n[i];
      end
      if (cfg_we) begin
        m_mode = cfg_level_mode;
        m_period = (cfg_div_sel == 2'b00) ? 8 : (cfg_div_sel == 2'b01) ? 16 : 128;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      logic [N_PIN-1:0] exp_oe;
      exp_oe = pin_oe_req & ~(pin_func_sel & {N_PIN{|m_flags}});
      checks++;
      if (fault_flags !== m_flags || pin_oe_out !== exp_oe) begin
        fails++;
        $display("FAIL model R2 R3 R4 R7 R9: flags act %h exp %h, oe act %h exp %h",
                 fault_flags, m_flags, pin_oe_out, exp_oe);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic [N_IN-1:0] mode, input logic [1:0] dv);
    @(negedge clk);
    cfg_level_mode = mode; cfg_div_sel = dv; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_flags(input logic [N_IN-1:0] d);
    @(negedge clk);
    flag_wdata = d; flag_we = 1'b1;
    @(negedge clk);
    flag_we = 1'b0; flag_wdata = '1;
  endtask

  task automatic measure(input int idx, input int lo, input int hi, input string req);
    int n = 0;
    @(negedge clk);
    fault_in_n[idx] = 1'b0;
    while (!fault_flags[idx] && n < 4000) begin
      @(negedge clk); n++;
    end
    check(n >= lo && n <= hi, req, "edge-to-flag latency", n, lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    model_on = 1'b1;
    // R1
    check(fault_flags == 0, "R1", "flags after reset", fault_flags, 0);
    check(pin_oe_out == pin_oe_req, "R1", "oe after reset", pin_oe_out, pin_oe_req);

    configure(4'b0010, 2'b00);
    cyc(20);
    // R2 edge on input 0
    fault_in_n[0] = 1'b0;
    cyc(40);
    check(fault_flags[0] == 1, "R2", "edge flag", fault_flags[0], 1);
    check(pin_oe_out == 6'b110000, "R7", "forced off", pin_oe_out, 6'b110000);
    pin_oe_req = 6'b101010;
    cyc(1);
    check(pin_oe_out == 6'b100000, "R8", "other-function pass", pin_oe_out, 6'b100000);
    pin_oe_req = 6'b111111;

    // R9 writing ones keeps flag
    write_flags(4'b1111);
    cyc(2);
    check(fault_flags[0] == 1, "R9", "write 1 keeps", fault_flags[0], 1);
    write_flags(4'b1110);
    cyc(1);
    check(fault_flags[0] == 0, "R9", "write 0 clears", fault_flags[0], 0);
    check(pin_oe_out == 6'b111111, "R7", "released", pin_oe_out, 6'b111111);
    cyc(100);
    check(fault_flags[0] == 0, "R5", "edge input still low", fault_flags[0], 0);
    fault_in_n[0] = 1'b1;
    cyc(30);

    // R3 level on input 1, 8-clock ticks
    fault_in_n[1] = 1'b0;
    cyc(12 * 8);
    check(fault_flags[1] == 0, "R3", "early level", fault_flags[1], 0);
    cyc(8 * 8);
    check(fault_flags[1] == 1, "R3", "level accepted", fault_flags[1], 1);
    write_flags(4'b1101);
    cyc(300);
    check(fault_flags[1] == 0, "R5", "stale low no rearm", fault_flags[1], 0);
    fault_in_n[1] = 1'b1;
    cyc(30);

    // R4 rejection then restart
    fault_in_n[1] = 1'b0;
    cyc(64);
    fault_in_n[1] = 1'b1;
    cyc(24);
    fault_in_n[1] = 1'b0;
    cyc(100);
    check(fault_flags[1] == 0, "R4", "rejected window", fault_flags[1], 0);
    cyc(60);
    check(fault_flags[1] == 1, "R4", "restart accepted", fault_flags[1], 1);
    write_flags(4'b1101);
    fault_in_n[1] = 1'b1;
    cyc(30);

    // R6 dividers
    configure(4'b1110, 2'b10);
    cyc(300);
    measure(2, 15 * 128, 17 * 128 + 8, "R6");
    write_flags(4'b1011);
    fault_in_n[2] = 1'b1;
    configure(4'b1110, 2'b01);
    cyc(60);
    measure(3, 15 * 16, 17 * 16 + 8, "R6");
    write_flags(4'b0111);
    fault_in_n[3] = 1'b1;
    configure(4'b1110, 2'b01);
    cyc(60);
    measure(0, 0, 16 + 8, "R6");
    cyc(4);
    check(fault_flags == 4'b0001, "R2", "only input 0 flagged", fault_flags, 1);
    write_flags(4'b1110);
    fault_in_n[0] = 1'b1;
    cyc(40);
    check(fault_flags == 0, "R9", "all clear", fault_flags, 0);

    model_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule